// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Read Option

This block carries data words from one clock domain to another. A producer writes on `wr_clk` and a consumer reads on `rd_clk`; the two clocks are unrelated. Between the storage array and the read port sits a single output register. It is not part of the occupancy that the flags report. Pointers cross between the domains as Gray codes through chains of two or more flip-flops. A flag therefore reacts at once to activity in its own domain and reacts late, by the synchronizer depth, to activity in the far domain.

The read behaviour is chosen while reset is held. The choice is held until the next reset.

- **Standard mode.** `rd_valid` acts as a not-empty flag for the storage array. A word reaches `rd_data` only after a read request is accepted, and it appears on the clock edge that accepts the request.
- **Fall-through mode.** `rd_valid` means the output register holds a word. When the register is empty and storage has data, the oldest word moves into the register by itself, and `rd_valid` rises on that same edge.

The write side follows valid/ready rules. A word is taken on a `wr_clk` edge where both `wr_valid` and `wr_ready` are high. With `wr_ready` low, `wr_valid` may stay high and nothing is stored. On the read side the consumer raises `rd_ready` to take a word. A request while `rd_valid` is low does nothing.

Two thresholds are also captured during reset:
- an almost-empty offset X;
- an almost-full offset Y.

Top module: `xfifo_dual`

## Requirements
- R1: While `rst_n` is low and after it is released with no traffic, `rd_valid` is 0, `rd_almost_empty_n` is 0, `wr_ready` is 1, `wr_almost_full_n` is 1, and `rd_data` is 0.
- R2: Words leave in the order they were accepted, with no loss and no duplication, in both modes.
- R3: In standard mode (`cfg_fwft`=0), `rd_data` changes only on a `rd_clk` edge with `rd_ready`=1 and `rd_valid`=1, and it then takes the oldest stored word. A request while `rd_valid`=0 leaves `rd_data` unchanged.
- R4: In fall-through mode (`cfg_fwft`=1), a word reaches `rd_data` with `rd_valid`=1 without any request. While `rd_ready`=0, `rd_valid` and `rd_data` hold.
- R5: The word held in the output register is not counted. In fall-through mode, N accepted and unread words (N ≥ 1) give a storage count of N−1, so storage can hold DEPTH words plus one word in the register.
- R6: In standard mode, `rd_valid` is 0 exactly when the storage count is 0.
- R7: `rd_almost_empty_n` is 0 when the storage count is X or less, and 1 when it is above X.
- R8: `wr_almost_full_n` is 0 when the storage count is DEPTH−Y or more. `wr_ready` is 0 exactly when the storage count equals DEPTH (16 by default).
- R9: A write offered while `wr_ready`=0 is discarded and moves no pointer.
- R10: A flag driven by a port's own operation changes on the same edge of that port's clock:
  - `wr_ready` falls on the edge that stores the last free slot;
  - `rd_valid` falls on the edge that takes the last word.
- R11: `cfg_fwft`, `cfg_ae_off` and `cfg_af_off` are sampled only while `rst_n` is low. Changes to them afterwards have no effect on the flags or the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset for both domains; configuration is captured while low |
| cfg_fwft | input | 1 | 1 = fall-through mode, 0 = standard mode |
| cfg_ae_off | input | ADDR_W | Almost-empty offset X |
| cfg_af_off | input | ADDR_W | Almost-full offset Y |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_data | input | DATA_W | Write word |
| wr_ready | output | 1 | Not full / input ready |
| wr_almost_full_n | output | 1 | Low when the storage count is DEPTH−Y or more |
| rd_ready | input | 1 | Consumer read request |
| rd_data | output | DATA_W | Output register |
| rd_valid | output | 1 | Not empty (standard) / output ready (fall-through) |
| rd_almost_empty_n | output | 1 | Low when the storage count is X or less |

## Verification
A pointer that drifts shows up at the read port as a word out of order, a repeat or a missing word, on the very next read that follows it. A wrong occupancy count shows up in the four flags. The bench compares these flags with a count it computes itself, once the synchronizers have had a few cycles to settle. A miscounted output register shows up as an almost-empty flag that is one word off in fall-through mode but correct in standard mode. An error in capturing the configuration shows up as thresholds that follow inputs changed after reset.

// File: rtl/xfifo_pkg.sv
`timescale 1ns/1ps
package xfifo_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/xfifo_sync.sv
`timescale 1ns/1ps
module xfifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xfifo_mem.sv
`timescale 1ns/1ps
module xfifo_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/xfifo_wr_ctl.sv
`timescale 1ns/1ps
module xfifo_wr_ctl #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_af_off,
  input  logic [ADDR_W:0]   rd_gray_async,
  input  logic              wr_valid,
  output logic              wen,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wr_bin,
  output logic [ADDR_W:0]   wr_gray,
  output logic [ADDR_W:0]   wr_cnt,
  output logic              wr_ready,
  output logic              af_n
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_C = {1'b1, {ADDR_W{1'b0}}};

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0]     rd_gray_s;
  logic [ADDR_W-1:0] af_q;
  logic [PW-1:0]     wr_bin_nx;
  logic [PW-1:0]     af_lim;

  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
    .clk(clk), .rst_n(rst_n), .d(rd_gray_async), .q(rd_gray_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) af_q <= cfg_af_off;
  end

  assign wr_cnt    = wr_bin - g2b(rd_gray_s);
  assign wr_ready  = (wr_cnt != DEPTH_C);
  assign wen       = wr_valid && wr_ready;
  assign waddr     = wr_bin[ADDR_W-1:0];
  assign wr_bin_nx = wr_bin + 1'b1;
  assign af_lim    = DEPTH_C - {1'b0, af_q};
  assign af_n      = !(wr_cnt >= af_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bin  <= '0;
      wr_gray <= '0;
    end else if (wen) begin
      wr_bin  <= wr_bin_nx;
      wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
    end
  end
endmodule

// File: rtl/xfifo_rd_ctl.sv
`timescale 1ns/1ps
module xfifo_rd_ctl
  import xfifo_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_fwft,
  input  logic [ADDR_W-1:0] cfg_ae_off,
  input  logic [ADDR_W:0]   wr_gray_async,
  input  logic              rd_ready,
  input  logic [DATA_W-1:0] mem_q,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rd_gray,
  output logic [ADDR_W:0]   rd_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              ae_n,
  output logic              mode_fwft
);
  localparam int PW = ADDR_W + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_mode_e          mode_q;
  logic [ADDR_W-1:0] ae_q;
  logic [PW-1:0]     wr_gray_s;
  logic [PW-1:0]     rd_bin;
  logic [PW-1:0]     rd_bin_nx;
  logic              ob_full;
  logic              mem_has;
  logic              pop;
  logic              ob_full_nx;

  xfifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst_n(rst_n), .d(wr_gray_async), .q(wr_gray_s)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= rd_mode_e'(cfg_fwft);
      ae_q   <= cfg_ae_off;
    end
  end

  assign mode_fwft = (mode_q == RD_FWFT);
  assign rd_cnt    = g2b(wr_gray_s) - rd_bin;
  assign mem_has   = (rd_cnt != '0);
  assign raddr     = rd_bin[ADDR_W-1:0];
  assign rd_bin_nx = rd_bin + 1'b1;
  assign ae_n      = (rd_cnt > {1'b0, ae_q});

  always_comb begin
    pop        = 1'b0;
    ob_full_nx = ob_full;
    if (mode_q == RD_FWFT) begin
      pop = mem_has && (!ob_full || rd_ready);
      if (pop)           ob_full_nx = 1'b1;
      else if (rd_ready) ob_full_nx = 1'b0;
    end else begin
      pop        = mem_has && rd_ready;
      ob_full_nx = 1'b0;
    end
  end

  assign rd_valid = (mode_q == RD_FWFT) ? ob_full : mem_has;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
      rd_data <= '0;
      ob_full <= 1'b0;
    end else begin
      ob_full <= ob_full_nx;
      if (pop) begin
        rd_bin  <= rd_bin_nx;
        rd_gray <= rd_bin_nx ^ (rd_bin_nx >> 1);
        rd_data <= mem_q;
      end
    end
  end
endmodule

// File: rtl/xfifo_dual.sv
`timescale 1ns/1ps
module xfifo_dual #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_fwft,
  input  logic [ADDR_W-1:0] cfg_ae_off,
  input  logic [ADDR_W-1:0] cfg_af_off,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              wr_almost_full_n,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_almost_empty_n
);
  logic              wen;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;
  logic [ADDR_W:0]   wr_bin;
  logic [ADDR_W:0]   wr_gray;
  logic [ADDR_W:0]   rd_gray;
  logic [ADDR_W:0]   wr_cnt;
  logic [ADDR_W:0]   rd_cnt;
  logic [DATA_W-1:0] mem_q;
  logic              mode_fwft;

  xfifo_wr_ctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .cfg_af_off(cfg_af_off),
    .rd_gray_async(rd_gray), .wr_valid(wr_valid), .wen(wen),
    .waddr(waddr), .wr_bin(wr_bin), .wr_gray(wr_gray), .wr_cnt(wr_cnt),
    .wr_ready(wr_ready), .af_n(wr_almost_full_n)
  );

  xfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(wen), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(mem_q)
  );

  xfifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .cfg_fwft(cfg_fwft), .cfg_ae_off(cfg_ae_off),
    .wr_gray_async(wr_gray), .rd_ready(rd_ready), .mem_q(mem_q),
    .raddr(raddr), .rd_gray(rd_gray), .rd_cnt(rd_cnt), .rd_data(rd_data),
    .rd_valid(rd_valid), .ae_n(rd_almost_empty_n), .mode_fwft(mode_fwft)
  );
endmodule

// File: rtl/xfifo_dual_chk.sv
`timescale 1ns/1ps
module xfifo_dual_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst_n,
  input logic              wr_ready,
  input logic              wr_almost_full_n,
  input logic [ADDR_W:0]   wr_bin,
  input logic [ADDR_W:0]   wr_cnt,
  input logic              rd_ready,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_almost_empty_n,
  input logic              mode_fwft
);
  localparam logic [ADDR_W:0] DEPTH_C = {1'b1, {ADDR_W{1'b0}}};

  // R9
  full_write_drop_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ready |=> $stable(wr_bin));

  // R8
  full_implies_af_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_ready |-> !wr_almost_full_n);

  // R8
  count_bound_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_cnt <= DEPTH_C);

  // R3
  std_data_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!mode_fwft && !(rd_valid && rd_ready)) |=> $stable(rd_data));

  // R4
  fwft_data_hold_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (mode_fwft && rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R7
  std_ae_nonempty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!mode_fwft && rd_almost_empty_n) |-> rd_valid);
endmodule

bind xfifo_dual xfifo_dual_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/xfifo_dual_tb.sv
`timescale 1ns/1ps
module xfifo_dual_tb;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic              cfg_fwft = 0;
  logic [ADDR_W-1:0] cfg_ae_off = '0, cfg_af_off = '0;
  logic              wr_valid = 0, rd_ready = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              wr_ready, wr_almost_full_n, rd_valid, rd_almost_empty_n;
  logic [DATA_W-1:0] rd_data;

  always #2.5 wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  xfifo_dual #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .cfg_fwft(cfg_fwft),
    .cfg_ae_off(cfg_ae_off), .cfg_af_off(cfg_af_off), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .wr_almost_full_n(wr_almost_full_n),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_almost_empty_n(rd_almost_empty_n)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [DATA_W-1:0] q[$];
  logic [DATA_W-1:0] last_rd;
  bit m_fwft;
  int m_x, m_y;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_mem(int total, bit fwft);
    if (fwft) return (total > 0) ? total - 1 : 0;
    return total;
  endfunction

  task automatic settle();
    repeat (8) @(negedge wr_clk);
    repeat (6) @(negedge rd_clk);
    @(negedge wr_clk);
  endtask

  task automatic check_flags(input string req);
    int m;
    bit e_rv, e_ae, e_af, e_wr;
    m    = exp_mem(q.size(), m_fwft);
    e_rv = m_fwft ? (q.size() > 0) : (m > 0);
    e_ae = (m > m_x);
    e_af = !(m >= DEPTH - m_y);
    e_wr = (m != DEPTH);
    check(rd_valid == e_rv, req, "rd_valid", rd_valid, e_rv);
    check(rd_almost_empty_n == e_ae, {req, "/R7"}, "almost_empty_n", rd_almost_empty_n, e_ae);
    check(wr_almost_full_n == e_af, {req, "/R8"}, "almost_full_n", wr_almost_full_n, e_af);
    check(wr_ready == e_wr, {req, "/R8"}, "wr_ready", wr_ready, e_wr);
  endtask

  task automatic do_reset(input bit fwft, input int x, input int y);
    rst_n = 0; wr_valid = 0; rd_ready = 0;
    cfg_fwft = fwft; cfg_ae_off = ADDR_W'(x); cfg_af_off = ADDR_W'(y);
    repeat (4) @(negedge wr_clk);
    repeat (4) @(negedge rd_clk);
    @(negedge wr_clk);
    rst_n = 1;
    q.delete(); last_rd = '0;
    m_fwft = fwft; m_x = x; m_y = y;
    // R11: disturb configuration after release; latched values must rule
    cfg_fwft = ~fwft; cfg_ae_off = ~ADDR_W'(x); cfg_af_off = ~ADDR_W'(y);
  endtask

  task automatic push(input logic [DATA_W-1:0] d, output bit acc);
    @(negedge wr_clk);
    acc = wr_ready;
    wr_valid = 1; wr_data = d;
    @(negedge wr_clk);
    wr_valid = 0;
    if (acc) q.push_back(d);
  endtask

  task automatic pop();
    bit v;
    logic [DATA_W-1:0] e;
    @(negedge rd_clk);
    v = rd_valid;
    if (m_fwft && v) begin
      e = q[0];
      check(rd_data == e, "R2/R4", "fwft head", rd_data, e);
    end
    rd_ready = 1;
    @(negedge rd_clk);
    rd_ready = 0;
    if (m_fwft) begin
      if (v) void'(q.pop_front());
    end else if (v) begin
      e = q.pop_front();
      check(rd_data == e, "R2/R3", "std data", rd_data, e);
      last_rd = e;
    end else begin
      check(rd_data == last_rd, "R3", "empty read ignored", rd_data, last_rd);
    end
  endtask

  task automatic run_mode(input bit fwft);
    bit acc;
    int n_acc;
    int cap;
    do_reset(fwft, 3, 2);
    check(rd_valid == 0 && rd_almost_empty_n == 0, "R1", "rd flags after reset",
          {rd_valid, rd_almost_empty_n}, 0);
    check(wr_ready == 1 && wr_almost_full_n == 1, "R1", "wr flags after reset",
          {wr_ready, wr_almost_full_n}, 3);
    check(rd_data == 0, "R1", "rd_data after reset", rd_data, 0);
    settle();
    check_flags("R11");

    // R5: X+1 words; fall-through keeps one outside the count
    for (int i = 0; i < 4; i++) push(DATA_W'(16'h100 + i), acc);
    settle();
    if (fwft) begin
      check(rd_valid == 1 && rd_data == 16'h100, "R4", "unrequested first word",
            rd_data, 16'h100);
      check(rd_almost_empty_n == 0, "R5", "ae with reg word excluded",
            rd_almost_empty_n, 0);
    end else begin
      check(rd_data == 0, "R3", "no data without request", rd_data, 0);
      check(rd_almost_empty_n == 1, "R5", "ae std count", rd_almost_empty_n, 1);
    end
    check_flags("R5");

    // Fill to full; extra offers must be dropped (R9), flag falls at once (R10)
    cap = fwft ? DEPTH + 1 : DEPTH;
    n_acc = q.size();
    for (int i = 0; i < DEPTH + 3; i++) begin
      push(DATA_W'(16'h200 + i), acc);
      if (acc) n_acc++;
      if (n_acc == cap && acc)
        check(wr_ready == 0, "R10", "wr_ready fall on last write", wr_ready, 0);
    end
    check(n_acc == cap, "R9", "accepted count at full", n_acc, cap);
    settle();
    check_flags("R8");

    // Drain all; rd_valid falls on the edge taking the last word
    while (q.size() > 0) begin
      pop();
      if (q.size() == 0)
        check(rd_valid == 0, "R10/R6", "rd_valid fall on last read", rd_valid, 0);
    end
    pop();
    settle();
    check_flags("R6");

    // Random mixed traffic
    for (int ph = 0; ph < 3; ph++) begin
      int wp;
      wp = (ph == 0) ? 75 : (ph == 1) ? 50 : 25;
      for (int k = 0; k < 120; k++) begin
        if ($urandom_range(99) < wp) push(DATA_W'($urandom), acc);
        else pop();
        if (k % 30 == 29) begin
          settle();
          check_flags("R2");
        end
      end
    end
    while (q.size() > 0) pop();
    settle();
    check_flags("R2");
  endtask

  initial begin
    void'($urandom(32'd5150));
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule